// File: doc/BRIEF.md
# Diagonal-Sweep Paeth Tile Reconstructor

This block rebuilds a square tile of 8-bit samples (8 by 8 by default) from a tile of Paeth residuals. Every sample is predicted from three neighbours: the one to its left, the one above it and the one diagonally up and to the left. The residual is then added to that prediction. A sample can only be rebuilt once those neighbours exist, so each row gets its own two-cycle predictor lane. The lanes run skewed, and the work moves across the tile one anti-diagonal at a time.

The caller presents the whole residual tile on `resid` and pulses `start` while the block is idle. The residuals are captured on that edge. Samples then appear in `pix`, one anti-diagonal every two cycles, and each new sample raises its own bit of `samp_vld` for one cycle. A one-cycle `done` pulse marks the final sample, and at that point the block is ready for the next tile. The rebuilt tile stays on `pix` until the next tile overwrites it.

Top module: `paeth_tile_dec`

## Requirements
- R1: The prediction uses p = a + b - c, formed with at least 10-bit signed precision. The predictor picks a when |p-a| is no larger than both |p-b| and |p-c|. Failing that, it picks b when |p-b| is no larger than |p-c|. Otherwise it picks c.
- R2: A rebuilt sample equals (residual + prediction) modulo 256. Any neighbour that falls outside the tile counts as 0. Sample (r,c) occupies byte 8r+c of `resid` and of `pix`, at bits [8(8r+c)+7 : 8(8r+c)].
- R3: Sample (r,c) appears on `pix` 2(r+c)+2 rising edges after the edge that accepted `start`. Its `samp_vld` bit 8r+c is high for exactly that one cycle, and no other bit of `samp_vld` is high at any other time. Successive anti-diagonals therefore land two cycles apart, and the last sample arrives 28 cycles after the first.
- R4: `done` is high for exactly one cycle, in the same cycle the last sample (7,7) appears, which is 30 edges after acceptance. `busy` falls in that same cycle.
- R5: `start` is accepted only on an edge where `busy` is low. From that edge `busy` stays high until `done`. The residuals are captured on the accepting edge, so `resid` may change afterwards without effect.
- R6: A `start` that arrives while `busy` is high has no effect. This holds even in the final busy cycle. The results, their timing and the idle state that follows are all unchanged.
- R7: While reset (`rst_n` low) is applied, `busy`, `done`, `samp_vld` and `pix` are all zero.
- R8: Between tiles, `pix` holds the last rebuilt tile, and `samp_vld` and `done` stay low.
- R9: A `start` raised during the `done` cycle is accepted on the next edge, so tiles can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a tile; ignored while busy |
| resid | input | 512 | Residual tile, byte 8r+c is sample (r,c) |
| busy | output | 1 | A tile is being rebuilt |
| done | output | 1 | One-cycle pulse with the final sample |
| samp_vld | output | 64 | Bit 8r+c pulses when sample (r,c) appears |
| pix | output | 512 | Rebuilt tile, byte 8r+c is sample (r,c) |

## Verification
The assertions assume that `start` and `resid` are synchronous to `clk`. They also assume that `rst_n` is held for at least one edge before any activity, so the step counter begins from a known value. The bench changes every input on the falling edge and releases reset before the first tile. When it raises `start` during a busy period, that is deliberate: the ignore rule needs exercising. In those cases it also corrupts `resid` at the same moment, to show that only the residuals captured at acceptance matter.

// File: rtl/paeth_pkg.sv
package paeth_pkg;

  localparam int PIX_W = 8;
  localparam int PRED_W = PIX_W + 2;

  typedef logic [PIX_W-1:0] pix_t;

  function automatic logic signed [PRED_W-1:0] widen(input pix_t v);
    return $signed({2'b00, v});
  endfunction

  function automatic logic signed [PRED_W-1:0] mag(input logic signed [PRED_W-1:0] v);
    return (v < 0) ? -v : v;
  endfunction

  // Paeth choice among left (a), above (b) and upper-left (c)
  function automatic pix_t paeth_pick(input pix_t a, input pix_t b, input pix_t c);
    logic signed [PRED_W-1:0] p, da, db, dc;
    p  = widen(a) + widen(b) - widen(c);
    da = mag(p - widen(a));
    db = mag(p - widen(b));
    dc = mag(p - widen(c));
    if (da <= db && da <= dc) return a;
    else if (db <= dc)        return b;
    else                      return c;
  endfunction

  function automatic pix_t rebuild(input pix_t res, input pix_t pred);
    return res + pred;
  endfunction

endpackage

// File: rtl/paeth_lane.sv
module paeth_lane
  import paeth_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic latch,
  input  logic fire,
  input  logic act,
  input  pix_t nb_a,
  input  pix_t nb_b,
  input  pix_t nb_c,
  input  pix_t res,
  output logic wr,
  output pix_t val
);

  pix_t a_q, b_q, c_q, r_q;
  logic act_q;

  // first half of the lane: capture neighbours and residual
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      c_q   <= '0;
      r_q   <= '0;
      act_q <= 1'b0;
    end else if (latch) begin
      a_q   <= nb_a;
      b_q   <= nb_b;
      c_q   <= nb_c;
      r_q   <= res;
      act_q <= act;
    end
  end

  // second half: predict and add
  assign wr  = fire & act_q;
  assign val = rebuild(r_q, paeth_pick(a_q, b_q, c_q));

endmodule

// File: rtl/paeth_sched.sv
module paeth_sched #(
  parameter int N = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  output logic                        busy,
  output logic                        accept,
  output logic                        phase,
  output logic [$clog2(4*N-2)-2:0]    diag,
  output logic                        done
);

  localparam int STEPS = 2 * (2 * N - 1);
  localparam int CW    = $clog2(STEPS);

  logic [CW-1:0] cnt;
  logic          last;

  assign accept = start & ~busy;
  assign last   = busy & (cnt == CW'(STEPS - 1));
  assign phase  = cnt[0];
  assign diag   = cnt[CW-1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= last;
      if (accept) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        if (last) busy <= 1'b0;
        else      cnt  <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/paeth_tile_dec.sv
module paeth_tile_dec
  import paeth_pkg::*;
#(
  parameter int N = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [N*N*PIX_W-1:0]   resid,
  output logic                   busy,
  output logic                   done,
  output logic [N*N-1:0]         samp_vld,
  output logic [N*N*PIX_W-1:0]   pix
);

  localparam int NN  = N * N;
  localparam int IW  = $clog2(NN);
  localparam int CIW = $clog2(N);
  localparam int DW  = $clog2(4*N-2) - 1;

  // named internal events
  logic          accept;
  logic          phase;
  logic [DW-1:0] diag;
  logic [N-1:0]  lane_wr;
  pix_t          lane_val [N];
  logic [IW-1:0] lane_idx [N];

  pix_t res_q [NN];
  pix_t pix_q [NN];

  paeth_sched #(.N(N)) u_sched (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .accept (accept),
    .phase  (phase),
    .diag   (diag),
    .done   (done)
  );

  for (genvar r = 0; r < N; r++) begin : g_lane
    logic           in_tile;
    logic [CIW-1:0] col_u;
    logic [IW-1:0]  cur_idx;
    pix_t           nb_a, nb_b, nb_c;

    always_comb begin
      int col_i;
      col_i   = int'(diag) - r;
      in_tile = (col_i >= 0) && (col_i < N);
      col_u   = in_tile ? col_i[CIW-1:0] : '0;
      cur_idx = IW'(r * N) + {{(IW-CIW){1'b0}}, col_u};
      nb_a    = (in_tile && col_u != '0)           ? pix_q[cur_idx - 1'b1]     : '0;
      nb_b    = (in_tile && r > 0)                 ? pix_q[cur_idx - IW'(N)]   : '0;
      nb_c    = (in_tile && r > 0 && col_u != '0)  ? pix_q[cur_idx - IW'(N+1)] : '0;
    end

    paeth_lane u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .latch (busy & ~phase),
      .fire  (busy & phase),
      .act   (in_tile),
      .nb_a  (nb_a),
      .nb_b  (nb_b),
      .nb_c  (nb_c),
      .res   (res_q[cur_idx]),
      .wr    (lane_wr[r]),
      .val   (lane_val[r])
    );

    assign lane_idx[r] = cur_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q    <= '{default: '0};
      pix_q    <= '{default: '0};
      samp_vld <= '0;
    end else begin
      samp_vld <= '0;
      if (accept) begin
        for (int i = 0; i < NN; i++) res_q[i] <= resid[i*PIX_W +: PIX_W];
      end
      for (int r = 0; r < N; r++) begin
        if (lane_wr[r]) begin
          pix_q[lane_idx[r]]    <= lane_val[r];
          samp_vld[lane_idx[r]] <= 1'b1;
        end
      end
    end
  end

  for (genvar i = 0; i < NN; i++) begin : g_out
    assign pix[i*PIX_W +: PIX_W] = pix_q[i];
  end

endmodule

// File: rtl/paeth_tile_chk.sv
module paeth_tile_chk #(
  parameter int N = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start,
  input logic                     busy,
  input logic                     done,
  input logic                     accept,
  input logic                     phase,
  input logic [$clog2(4*N-2)-2:0] diag,
  input logic [N*N-1:0]           samp_vld
);

  localparam int DMAX = 2 * N - 2;

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R3
  last_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (samp_vld[N*N-1] && $countones(samp_vld) == 1));

  // R3
  diag_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(samp_vld) <= N);

  // R3
  vld_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_vld != '0) |-> $past(busy));

  // R5
  accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && diag == '0 && !phase));

  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && phase && int'(diag) != DMAX) |=> (busy && !phase && diag == $past(diag) + 1'b1));

endmodule

bind paeth_tile_dec paeth_tile_chk #(.N(N)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .accept   (accept),
  .phase    (phase),
  .diag     (diag),
  .samp_vld (samp_vld)
);

// File: tb/sim_paeth_tile_dec.sv
module sim_paeth_tile_dec;

  localparam int N  = 8;
  localparam int NN = N * N;
  localparam int W  = 8;
  localparam int KL = 2 * (2 * N - 2) + 2;

  // stimulus table: {mode, p1, p2, p3}
  // mode 0 constant p1, 1 ramp p1+r*p2+c*p3, 2 pseudo-random seed p1, 3 checker p1/p2
  localparam logic [31:0] VEC [7] = '{
    32'h00_00_00_00, 32'h00_FF_00_00, 32'h01_10_03_05, 32'h01_00_F0_11,
    32'h02_5A_00_00, 32'h03_80_7F_00, 32'h02_C3_00_00
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NN*W-1:0] resid = '0;
  wire  busy, done;
  wire  [NN-1:0]   samp_vld;
  wire  [NN*W-1:0] pix;

  always #4 clk = ~clk;

  paeth_tile_dec u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .resid(resid),
    .busy(busy), .done(done), .samp_vld(samp_vld), .pix(pix)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [7:0] exp_t [NN];

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // reference predictor written with distances in terms of the neighbours
  function automatic int ref_pred(input int a, input int b, input int c);
    int da, db, dc;
    da = (b > c) ? b - c : c - b;
    db = (a > c) ? a - c : c - a;
    dc = (a + b > 2 * c) ? a + b - 2 * c : 2 * c - a - b;
    if (da <= db && da <= dc) return a;
    if (db <= dc) return b;
    return c;
  endfunction

  task automatic build_ref(input logic [NN*W-1:0] rv);
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < N; c++) begin
        int a, b, d;
        a = (c > 0) ? int'(exp_t[r*N+c-1]) : 0;
        b = (r > 0) ? int'(exp_t[(r-1)*N+c]) : 0;
        d = (r > 0 && c > 0) ? int'(exp_t[(r-1)*N+c-1]) : 0;
        exp_t[r*N+c] = 8'((int'(rv[(r*N+c)*W +: W]) + ref_pred(a, b, d)) % 256);
      end
    end
  endtask

  function automatic logic [NN*W-1:0] gen_tile(input logic [31:0] v);
    logic [NN*W-1:0] t;
    logic [31:0] s;
    s = {24'h0, v[23:16]} + 32'd1;
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < N; c++) begin
        logic [7:0] b;
        case (v[31:24])
          8'd0: b = v[23:16];
          8'd1: b = 8'(v[23:16] + 8'(r) * v[15:8] + 8'(c) * v[7:0]);
          8'd2: begin s = s * 32'd1103515245 + 32'd12345; b = s[23:16]; end
          default: b = ((r + c) % 2 == 1) ? v[23:16] : v[15:8];
        endcase
        t[(r*N+c)*W +: W] = b;
      end
    end
    return t;
  endfunction

  function automatic logic [NN*W-1:0] exp_flat();
    logic [NN*W-1:0] f;
    for (int i = 0; i < NN; i++) f[i*W +: W] = exp_t[i];
    return f;
  endfunction

  // pre: start already driven by a previous call; poke: busy cycle to raise start
  task automatic run_tile(input logic [NN*W-1:0] rv, input bit pre, input int poke,
                          input bit chain, input logic [NN*W-1:0] nxt);
    build_ref(rv);
    if (!pre) begin
      @(negedge clk);
      resid = rv;
      start = 1'b1;
    end
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done, pre ? "R9" : "R5", "busy after accept", {62'd0, busy, done}, 64'd2);
    for (int k = 1; k <= KL; k++) begin
      logic [NN-1:0] mask;
      @(negedge clk);
      if (k == poke + 1) start = 1'b0;
      for (int i = 0; i < NN; i++) mask[i] = (2 * (i / N + i % N) + 2 == k);
      // R3: exact cycle of each anti-diagonal
      chk(samp_vld == mask, "R3", "valid mask", samp_vld, mask);
      chk(done == (k == KL) && busy == (k < KL), "R4", "done/busy",
          {62'd0, done, busy}, {62'd0, k == KL, k < KL});
      for (int i = 0; i < NN; i++)
        if (samp_vld[i]) chk(pix[i*W +: W] == exp_t[i], "R2", "sample value",
                             64'(pix[i*W +: W]), 64'(exp_t[i]));
      if (k == KL) begin
        for (int i = 0; i < NN; i++)
          chk(pix[i*W +: W] == exp_t[i], "R1", "tile sample", 64'(pix[i*W +: W]), 64'(exp_t[i]));
        if (chain) begin
          resid = nxt;
          start = 1'b1;
        end
      end
      if (k == poke) begin
        start = 1'b1;
        resid = ~rv;
      end
    end
  endtask

  task automatic idle_check(input string req, input int cycles);
    for (int j = 0; j < cycles; j++) begin
      @(negedge clk);
      chk(pix == exp_flat(), req, "held tile", 64'(pix[63:0]), 64'(exp_flat()));
      chk(samp_vld == '0 && !done && !busy, req, "idle outputs",
          {busy, done, 62'(samp_vld)}, 64'd0);
    end
  endtask

  initial begin
    // R7: reset state
    start = 1'b1;
    repeat (3) @(negedge clk);
    chk(pix == '0, "R7", "pix in reset", 64'(pix[63:0]), 64'd0);
    chk(!busy && !done && samp_vld == '0, "R7", "flags in reset",
        {busy, done, 62'(samp_vld)}, 64'd0);
    start = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy, "R5", "no start without request", {63'd0, busy}, 64'd0);

    // table walk
    for (int v = 0; v < 7; v++) begin
      run_tile(gen_tile(VEC[v]), 1'b0, -5, 1'b0, '0);
      idle_check("R8", 2);
    end

    // R6: start mid-run with corrupted residuals is ignored
    run_tile(gen_tile(32'h02_17_00_00), 1'b0, 5, 1'b0, '0);
    idle_check("R6", 3);

    // R6: start in the last busy cycle is ignored
    run_tile(gen_tile(32'h01_33_09_FD), 1'b0, KL - 1, 1'b0, '0);
    start = 1'b0;
    idle_check("R6", 3);

    // R9: back-to-back tiles, start raised during done
    run_tile(gen_tile(32'h02_99_00_00), 1'b0, -5, 1'b1, gen_tile(32'h03_FF_01_00));
    run_tile(gen_tile(32'h03_FF_01_00), 1'b1, -5, 1'b0, '0);
    idle_check("R8", 2);

    summary();
  end

endmodule